// File: doc/BRIEF.md
# ECC Error Status Logging Register

This block is the error-status word of a memory controller's ECC logic. An upstream ECC checker raises one-cycle pulses for uncorrectable and correctable errors, each pulse carrying the chip-select row that produced it. The block turns each pulse into a sticky flag and records the row. It also holds the software-owned control fields: the ECC mode, a diagnostic enable and one system-error interrupt enable per error class. Software reads all of this as one 32-bit word.

Software writes the same word to change the control fields. In the same write it acknowledges errors by writing ones to the flag positions. The row of the first error in a class is kept until software acknowledges that class, so the first failing row is not lost to later events. A level interrupt request is raised while any flag is set and its class is enabled.

The block holds state only. Error detection, correction, scrubbing and the bus front end sit outside it. Every output is taken straight from registers. The effect of an input is therefore visible one clock after the edge that samples it.

Top module: `ecc_err_status_reg`

## Requirements
- R1: An uncorrectable pulse sampled while the mode field (bits 11:10) is nonzero sets bit 8 at the next clock edge. A correctable pulse under the same condition sets bit 9.
- R2: A write with bit 8 (or bit 9) at 1 clears that flag at the next edge. A write with that bit at 0 leaves the flag as it was.
- R3: When a flag goes from clear to set, the row that came with the pulse is recorded: the uncorrectable row in bits 7:4 and the correctable row in bits 3:0. Writes never change these fields.
- R4: While a flag is set, its row field stays fixed, so later pulses of that class keep the first row. After a clear, the field still shows the old row until the next capture.
- R5: If a pulse and a write-one-to-clear of the same flag arrive in the same cycle, the flag stays set.
- R6: A write loads the mode field, bits 11:10 (0 off, 1 detect only, 2 single-correct double-detect, 3 correct plus scrub), and the new value reads back after the edge.
- R7: In mode 0, error pulses are ignored. The mode in force is the value held before any write in the same cycle.
- R8: Bit 14 enables the interrupt for uncorrectable errors and bit 15 for correctable errors. The interrupt output is high exactly when (bit 8 and bit 14) or (bit 9 and bit 15).
- R9: Bit 12 is a writable diagnostic enable that reads back as written. Bit 13 and bits 31:16 always read 0.
- R10: After reset the readback word is 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ue_pulse_i | input | 1 | One-cycle uncorrectable error event |
| ue_row_i | input | 4 | Chip-select row of the uncorrectable event |
| ce_pulse_i | input | 1 | One-cycle correctable error event |
| ce_row_i | input | 4 | Chip-select row of the correctable event |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register readback word |
| serr_irq_o | output | 1 | System-error interrupt request |

## Verification
The directed patterns are chosen to tell apart behaviours that a shallow test would confuse:
- Pulses are sent in mode 0, and again in the cycle that turns the mode on. This separates "ignored" from "captured", and shows that the mode held before the write decides.
- A repeat pulse arrives with a different row, which shows first-row retention.
- Zero and one writes go to the flag bits, separating the hold and clear paths.
- A pulse and a clear of the same flag are sent together, which shows that the event has priority.
- Enables are set one class at a time, which shows that each flag is gated only by its own enable.

A random phase then mixes pulses, rows and writes, and is compared every cycle against a behavioural model.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

   // Class index used across the block: 0 = uncorrectable, 1 = correctable.
   localparam int NUM_CLASSES = 2;
   localparam int CLS_UE      = 0;
   localparam int CLS_CE      = 1;

   // Field positions software decodes in the status word.
   localparam int FLAG_LSB    = 8;   // flag of class k at FLAG_LSB + k
   localparam int MODE_LSB    = 10;
   localparam int MODE_W      = 2;
   localparam int DIAG_BIT    = 12;
   localparam int EN_LSB      = 14;  // enable of class k at EN_LSB + k
   localparam int USED_W      = 16;  // bits at and above this read zero

   typedef enum logic [MODE_W-1:0] {
      MODE_OFF    = 2'd0,
      MODE_DETECT = 2'd1,
      MODE_SECDED = 2'd2,
      MODE_SCRUB  = 2'd3
   } ecc_mode_e;

endpackage

// File: rtl/ecc_err_slot.sv
module ecc_err_slot #(
   parameter int ROW_W      = 4,
   parameter bit HOLD_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             arm_i,
   input  logic             clr_i,
   output logic             flag_o,
   output logic [ROW_W-1:0] row_o
);

   logic             flag_q;
   logic [ROW_W-1:0] row_q;
   logic             take;
   logic             load_row;
   logic             flag_d;

   // An event only counts while the ECC logic is armed.
   assign take = evt_i & arm_i;

   // Event has priority over a software clear in the same cycle.
   always_comb begin
      if (take)
         flag_d = 1'b1;
      else if (clr_i)
         flag_d = 1'b0;
      else
         flag_d = flag_q;
   end

   generate
      if (HOLD_FIRST) begin : g_first
         // Capture only on the clear-to-set transition.
         assign load_row = take & ~flag_q;
      end else begin : g_latest
         // Every accepted event overwrites the row.
         assign load_row = take;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         row_q  <= '0;
      end else begin
         flag_q <= flag_d;
         if (load_row)
            row_q <= row_i;
      end
   end

   assign flag_o = flag_q;
   assign row_o  = row_q;

endmodule

// File: rtl/ecc_ctrl_fields.sv
module ecc_ctrl_fields
   import ecc_stat_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [DATA_W-1:0]      wr_data_i,
   output ecc_mode_e              mode_o,
   output logic                   diag_o,
   output logic [NUM_CLASSES-1:0] en_o,
   output logic                   arm_o
);

   ecc_mode_e              mode_q;
   logic                   diag_q;
   logic [NUM_CLASSES-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         diag_q <= 1'b0;
         en_q   <= '0;
      end else if (wr_en_i) begin
         mode_q <= ecc_mode_e'(wr_data_i[MODE_LSB +: MODE_W]);
         diag_q <= wr_data_i[DIAG_BIT];
         en_q   <= wr_data_i[EN_LSB +: NUM_CLASSES];
      end
   end

   // Capture is armed from the held mode, before any write this cycle.
   assign arm_o  = (mode_q != MODE_OFF);
   assign mode_o = mode_q;
   assign diag_o = diag_q;
   assign en_o   = en_q;

   // Remaining write bits are owned by other slices of the word.
   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data_i[DATA_W-1:EN_LSB+NUM_CLASSES],
                             wr_data_i[DIAG_BIT+1 +: EN_LSB-DIAG_BIT-1],
                             wr_data_i[MODE_LSB-1:0]};

endmodule

// File: rtl/ecc_status_pack.sv
module ecc_status_pack
   import ecc_stat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ROW_W  = 4
) (
   input  logic [NUM_CLASSES-1:0]            flag_i,
   input  logic [NUM_CLASSES-1:0][ROW_W-1:0] row_i,
   input  ecc_mode_e                         mode_i,
   input  logic                              diag_i,
   input  logic [NUM_CLASSES-1:0]            en_i,
   output logic [DATA_W-1:0]                 rd_data_o,
   output logic                              irq_o
);

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NUM_CLASSES; k++) begin
         // Correctable row sits lowest, uncorrectable row above it.
         rd_data_o[(NUM_CLASSES-1-k)*ROW_W +: ROW_W] = row_i[k];
         rd_data_o[FLAG_LSB + k] = flag_i[k];
         rd_data_o[EN_LSB + k]   = en_i[k];
      end
      rd_data_o[MODE_LSB +: MODE_W] = mode_i;
      rd_data_o[DIAG_BIT]           = diag_i;
   end

   assign irq_o = |(flag_i & en_i);

endmodule

// File: rtl/ecc_err_status_reg.sv
module ecc_err_status_reg
   import ecc_stat_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ROW_W      = 4,
   parameter int NUM_ROWS   = 8,
   parameter bit HOLD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ue_pulse_i,
   input  logic [ROW_W-1:0]  ue_row_i,
   input  logic              ce_pulse_i,
   input  logic [ROW_W-1:0]  ce_row_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              serr_irq_o
);

   localparam int ROW_FIELD_W = NUM_CLASSES * ROW_W;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < USED_W) begin : g_bad_width
         $error("DATA_W must cover the defined fields");
      end
      if (ROW_W < 1 || ROW_FIELD_W > FLAG_LSB) begin : g_bad_row
         $error("row fields must fit below the flag bits");
      end
      if (NUM_ROWS < 1 || NUM_ROWS > (1 << ROW_W)) begin : g_bad_rows
         $error("NUM_ROWS must be addressable with ROW_W bits");
      end
   endgenerate

   logic [NUM_CLASSES-1:0]            evt;
   logic [NUM_CLASSES-1:0][ROW_W-1:0] evt_row;
   logic [NUM_CLASSES-1:0]            clr;
   logic [NUM_CLASSES-1:0]            flag;
   logic [NUM_CLASSES-1:0][ROW_W-1:0] row;
   ecc_mode_e                         mode;
   logic                              diag;
   logic [NUM_CLASSES-1:0]            en;
   logic                              arm;

   assign evt[CLS_UE]     = ue_pulse_i;
   assign evt[CLS_CE]     = ce_pulse_i;
   assign evt_row[CLS_UE] = ue_row_i;
   assign evt_row[CLS_CE] = ce_row_i;

   ecc_ctrl_fields #(
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .mode_o    (mode),
      .diag_o    (diag),
      .en_o      (en),
      .arm_o     (arm)
   );

   generate
      for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
         // Write-one-to-clear on the class's flag position.
         assign clr[k] = wr_en_i & wr_data_i[FLAG_LSB + k];

         ecc_err_slot #(
            .ROW_W      (ROW_W),
            .HOLD_FIRST (HOLD_FIRST)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt[k]),
            .row_i  (evt_row[k]),
            .arm_i  (arm),
            .clr_i  (clr[k]),
            .flag_o (flag[k]),
            .row_o  (row[k])
         );
      end
   endgenerate

   ecc_status_pack #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W)
   ) u_pack (
      .flag_i    (flag),
      .row_i     (row),
      .mode_i    (mode),
      .diag_i    (diag),
      .en_i      (en),
      .rd_data_o (rd_data_o),
      .irq_o     (serr_irq_o)
   );

endmodule

// File: rtl/ecc_err_status_chk.sv
module ecc_err_status_chk #(
   parameter int DATA_W = 32,
   parameter int ROW_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ue_pulse_i,
   input logic [ROW_W-1:0]  ue_row_i,
   input logic              ce_pulse_i,
   input logic [ROW_W-1:0]  ce_row_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              serr_irq_o
);

   logic       ue_f, ce_f, ue_clr, ce_clr, armed;
   logic [1:0] mode_rd;

   assign ue_f    = rd_data_o[8];
   assign ce_f    = rd_data_o[9];
   assign mode_rd = rd_data_o[11:10];
   assign armed   = (mode_rd != 2'd0);
   assign ue_clr  = wr_en_i & wr_data_i[8];
   assign ce_clr  = wr_en_i & wr_data_i[9];

   // R1
   ue_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_pulse_i && armed) |=> ue_f);
   // R1
   ce_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_pulse_i && armed) |=> ce_f);
   // R2
   ue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_f && !ue_clr) |=> ue_f);
   // R2
   ue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_f && ue_clr && !ue_pulse_i) |=> !ue_f);
   // R2
   ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_f && ce_clr && !ce_pulse_i) |=> !ce_f);
   // R3
   ue_row_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ue_f && ue_pulse_i && armed) |=> (rd_data_o[2*ROW_W-1:ROW_W] == $past(ue_row_i)));
   // R3
   ce_row_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_f && ce_pulse_i && armed) |=> (rd_data_o[ROW_W-1:0] == $past(ce_row_i)));
   // R4
   ue_row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ue_f |=> $stable(rd_data_o[2*ROW_W-1:ROW_W]));
   // R4
   ce_row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_f |=> $stable(rd_data_o[ROW_W-1:0]));
   // R5
   ue_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_pulse_i && armed && ue_clr) |=> ue_f);
   // R6
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (mode_rd == $past(wr_data_i[11:10])));
   // R7
   off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !ue_f && !ce_f) |=> (!ue_f && !ce_f));
   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serr_irq_o == ((ue_f && rd_data_o[14]) || (ce_f && rd_data_o[15])));
   // R9
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data_o[13] && ((rd_data_o >> 16) == '0)));

   logic unused_chk;
   assign unused_chk = ^{wr_data_i, rd_data_o[12]};

endmodule

bind ecc_err_status_reg ecc_err_status_chk #(
   .DATA_W (DATA_W),
   .ROW_W  (ROW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ue_pulse_i (ue_pulse_i),
   .ue_row_i   (ue_row_i),
   .ce_pulse_i (ce_pulse_i),
   .ce_row_i   (ce_row_i),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .rd_data_o  (rd_data_o),
   .serr_irq_o (serr_irq_o)
);

// File: tb/test_ecc_err_status_reg.sv
module test_ecc_err_status_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ue_pulse_i = 1'b0;
   logic [3:0]  ue_row_i = '0;
   logic        ce_pulse_i = 1'b0;
   logic [3:0]  ce_row_i = '0;
   logic        wr_en_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] rd_data_o;
   logic        serr_irq_o;

   int    n_checks = 0;
   int    n_fails  = 0;
   int    cyc      = 0;
   string cur_req  = "R10";

   ecc_err_status_reg i_ecc_err_status_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ue_pulse_i (ue_pulse_i),
      .ue_row_i   (ue_row_i),
      .ce_pulse_i (ce_pulse_i),
      .ce_row_i   (ce_row_i),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .rd_data_o  (rd_data_o),
      .serr_irq_o (serr_irq_o)
   );

   always #4 clk = ~clk;   // 125 MHz

   // Behavioural reference model, kept as plain integers.
   int m_ue = 0, m_ce = 0, m_ue_row = 0, m_ce_row = 0;
   int m_mode = 0, m_diag = 0, m_en_ue = 0, m_en_ce = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ue = 0; m_ce = 0; m_ue_row = 0; m_ce_row = 0;
         m_mode = 0; m_diag = 0; m_en_ue = 0; m_en_ce = 0;
      end else begin
         int  mode_before;
         bit  ue_ack, ce_ack;
         mode_before = m_mode;
         ue_ack = wr_en_i && wr_data_i[8];
         ce_ack = wr_en_i && wr_data_i[9];
         if (ue_pulse_i && mode_before != 0) begin
            if (m_ue == 0) m_ue_row = int'(ue_row_i);
            m_ue = 1;
         end else if (ue_ack) m_ue = 0;
         if (ce_pulse_i && mode_before != 0) begin
            if (m_ce == 0) m_ce_row = int'(ce_row_i);
            m_ce = 1;
         end else if (ce_ack) m_ce = 0;
         if (wr_en_i) begin
            m_mode  = int'(wr_data_i[11:10]);
            m_diag  = int'(wr_data_i[12]);
            m_en_ue = int'(wr_data_i[14]);
            m_en_ce = int'(wr_data_i[15]);
         end
      end
   end

   function automatic logic [31:0] model_word();
      return (32'(m_en_ce) << 15) | (32'(m_en_ue) << 14) | (32'(m_diag) << 12)
           | (32'(m_mode) << 10) | (32'(m_ce) << 9) | (32'(m_ue) << 8)
           | (32'(m_ue_row) << 4) | 32'(m_ce_row);
   endfunction

   // Per-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         logic exp_irq;
         exp_irq = ((m_ue != 0) && (m_en_ue != 0)) || ((m_ce != 0) && (m_en_ce != 0));
         n_checks++;
         if (rd_data_o !== model_word()) begin
            n_fails++;
            $display("FAIL %s readback act=%h exp=%h", cur_req, rd_data_o, model_word());
         end
         n_checks++;
         if (serr_irq_o !== exp_irq) begin
            n_fails++;
            $display("FAIL %s irq act=%b exp=%b", cur_req, serr_irq_o, exp_irq);
         end
      end
   end

   // Watchdog.
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fails++;
         $display("FAIL watchdog act=%0d cycles exp=<20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs at a falling edge; return at the next one.
   task automatic step(input bit ue, input logic [3:0] ur, input bit ce,
                       input logic [3:0] cr, input bit we, input logic [31:0] wd);
      ue_pulse_i = ue; ue_row_i = ur;
      ce_pulse_i = ce; ce_row_i = cr;
      wr_en_i = we;   wr_data_i = wd;
      @(negedge clk);
      ue_pulse_i = 1'b0; ce_pulse_i = 1'b0; wr_en_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10", rd_data_o, 32'h0);
      chk("R10", {31'b0, serr_irq_o}, 32'h0);

      cur_req = "R7";
      step(1, 4'd3, 1, 4'd6, 0, '0);
      chk("R7", rd_data_o, 32'h0);                 // mode 0, pulses ignored
      step(1, 4'd4, 0, 4'd0, 1, 32'h0000_0C00);
      chk("R7", rd_data_o, 32'h0000_0C00);         // old mode 0 still gates

      cur_req = "R1";
      step(1, 4'd5, 0, 4'd0, 0, '0);
      chk("R1", rd_data_o, 32'h0000_0D50);         // R3: row 5 in bits 7:4

      cur_req = "R4";
      step(1, 4'd2, 1, 4'd7, 0, '0);
      chk("R4", rd_data_o, 32'h0000_0F57);         // UE row kept at 5

      cur_req = "R2";
      step(0, 4'd0, 0, 4'd0, 1, 32'h0000_0C00);
      chk("R2", rd_data_o, 32'h0000_0F57);         // zeros leave flags
      step(0, 4'd0, 0, 4'd0, 1, 32'h0000_0D00);
      chk("R2", rd_data_o, 32'h0000_0E57);         // UE cleared, row kept

      cur_req = "R5";
      step(0, 4'd0, 1, 4'd1, 1, 32'h0000_0E00);
      chk("R5", rd_data_o, 32'h0000_0E57);         // event beats clear

      cur_req = "R8";
      step(0, 4'd0, 0, 4'd0, 1, 32'h0000_8C00);
      chk("R8", rd_data_o, 32'h0000_8E57);
      chk("R8", {31'b0, serr_irq_o}, 32'h1);
      step(0, 4'd0, 0, 4'd0, 1, 32'h0000_4C00);
      chk("R8", {31'b0, serr_irq_o}, 32'h0);       // CE set but not enabled
      step(1, 4'd0, 0, 4'd0, 0, '0);
      chk("R3", rd_data_o, 32'h0000_4F07);         // UE row 0 captured
      chk("R8", {31'b0, serr_irq_o}, 32'h1);

      cur_req = "R9";
      step(0, 4'd0, 0, 4'd0, 1, 32'hFFFF_FFFF);
      chk("R9", rd_data_o, 32'h0000_DC07);         // reserved zero, diag set
      chk("R9", {31'b0, serr_irq_o}, 32'h0);

      cur_req = "R6";
      step(0, 4'd0, 0, 4'd0, 1, 32'h0000_0800);
      chk("R6", rd_data_o, 32'h0000_0807);
      step(0, 4'd0, 0, 4'd0, 1, 32'h0000_0400);
      step(0, 4'd0, 1, 4'd3, 0, '0);
      chk("R6", rd_data_o, 32'h0000_0603);         // detect-only mode captures

      // Mixed random traffic, compared every cycle against the model.
      cur_req = "R4";
      for (int i = 0; i < 600; i++) begin
         logic [31:0] wd;
         wd = $urandom;
         if (($urandom % 8) != 0) wd[11:10] = 2'(1 + $urandom % 3);
         step(($urandom % 3) == 0, 4'($urandom % 8),
              ($urandom % 3) == 0, 4'($urandom % 8),
              ($urandom % 4) == 0, wd);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule